// File: doc/BRIEF.md
# Display Test Pattern Generator

The block sits in a display pixel path and, when enabled, substitutes generated test content for the active pixels of each frame. Five pattern families are provided. Colour squares come in full-range or limited-range levels. Vertical and horizontal bars alternate between two programmable colours. A single-slope grey ramp and a two-slope dual ramp complete the set. Each output component is reduced to 6, 8, 10 or 12 significant bits, aligned to the top of a 16-bit field.

The block is configured through a small write port with three targets: control, geometry/ramp parameters and the bar colours. The six bar colour components are loaded through a one-deep mask pipeline. Each colour write carries a one-hot mask and a data word. The data goes into the component that the mask of the previous colour write chose, so loading all six components takes seven writes. Outside active pixels, or while the generator is off, the incoming video passes through unchanged. Every result appears on the output one clock after its inputs.

Top module: `test_pattern_gen`

## Requirements
- R1: While `rst_n` is low, `pix_out` is zero; after reset the generator is off and all bar colours and the pending mask are zero.
- R2: `pix_out` equals the `video_in` sampled one clock earlier whenever, at that clock, `pix_active` was low, the control enable bit was clear, or the control mode code was 5, 6 or 7.
- R3: A colour write (`cfg_sel`=2) carries data in `cfg_wdata[15:0]` and a mask in `cfg_wdata[21:16]`. Mask bits 0..5 select R0, G0, B0, R1, G1, B1. The data is stored into every component whose bit was set in the mask of the previous colour write, and the new mask then becomes pending. The pending mask is zero after reset.
- R4: Bits 5..0 of every stored colour component read as zero, whatever the written data holds.
- R5: Mode code 1 (vertical bars) gives colour set 0 (R0,G0,B0) where bit 0 of `pix_x >> hres` is 0, and colour set 1 where it is 1.
- R6: Mode code 2 (horizontal bars) chooses between the two colour sets in the same way, using bit 0 of `pix_y >> vres`.
- R7: Mode code 0 (colour squares) forms k = ((`pix_x`>>hres) + (`pix_y`>>vres)) mod 8. Red is high when k bit 2 is set, green when k bit 1 is set and blue when k bit 0 is set. High/low levels are FFFF/0000 when the range bit is 0 and EB00/1000 when it is 1.
- R8: Mode code 3 (single ramp) drives all three components with offset + ((`pix_x`>>hres) << inc0), saturated at FFFF.
- R9: Mode code 4 (dual ramp) behaves as R8 on line bands where bit 0 of `pix_y >> vres` is 0. On the other bands it uses (`pix_x`>>hres) << inc1 starting from zero, saturated at FFFF.
- R10: Depth code 0/1/2/3 keeps the top 6/8/10/12 bits of each generated component and clears the rest.
- R11: Control (`cfg_sel`=0) packs enable in bit 0, mode in bits 3:1, range in bit 4 and depth in bits 6:5. Writing 0 returns the output to pass-through from the next pixel on, and writing 0 to all three targets leaves nothing active.
- R12: Parameters (`cfg_sel`=1) pack inc0 in bits 3:0, inc1 in bits 7:4, hres in bits 11:8, vres in bits 15:12 and the ramp offset in bits 31:16. A write takes effect on the pixel sampled at the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 control, 1 parameters, 2 colour |
| cfg_wdata | input | 32 | Write data |
| pix_x | input | COORD_W | Horizontal pixel position within the active area |
| pix_y | input | COORD_W | Vertical line position within the active area |
| pix_active | input | 1 | High on active pixels |
| video_in | input | 48 | Incoming pixel {R,G,B}, 16 bits each |
| pix_out | output | 48 | Output pixel {R[47:32],G[31:16],B[15:0]} |

## Verification
Every pixel result is due exactly one clock after the position, active flag and video word that produced it. A configuration write changes the pixel sampled at the next clock, not the one sampled with it. Colour data written with a given mask shows up only after the following colour write has been issued. The bench drives inputs on the falling edge and predicts each output from its own model of the state before the rising edge. It then folds the write into that model and compares the output on the next falling edge, so every clock is checked against a prediction aligned to that latency.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
   localparam int TPG_CW = 16;   // component width of the output and colour store
   localparam int TPG_NSLOT = 6; // R0 G0 B0 R1 G1 B1

   localparam logic [1:0] SEL_CTRL   = 2'd0;
   localparam logic [1:0] SEL_PARAM  = 2'd1;
   localparam logic [1:0] SEL_COLOUR = 2'd2;

   localparam logic [2:0] MODE_SQUARES = 3'd0;
   localparam logic [2:0] MODE_VBARS   = 3'd1;
   localparam logic [2:0] MODE_HBARS   = 3'd2;
   localparam logic [2:0] MODE_RAMP1   = 3'd3;
   localparam logic [2:0] MODE_RAMP2   = 3'd4;

   localparam logic [1:0] DEPTH_6  = 2'd0;
   localparam logic [1:0] DEPTH_8  = 2'd1;
   localparam logic [1:0] DEPTH_10 = 2'd2;
   localparam logic [1:0] DEPTH_12 = 2'd3;

   typedef struct packed {
      logic [1:0] depth;
      logic       cea;
      logic [2:0] mode;
      logic       en;
   } tpg_ctrl_t;

   typedef struct packed {
      logic [TPG_CW-1:0] ofs;
      logic [3:0]        vres;
      logic [3:0]        hres;
      logic [3:0]        inc1;
      logic [3:0]        inc0;
   } tpg_param_t;

   typedef logic [TPG_NSLOT-1:0][TPG_CW-1:0] tpg_slots_t;
   typedef logic [2:0][TPG_CW-1:0]           tpg_rgb_t;
endpackage

// File: rtl/tpg_regs.sv
module tpg_regs
   import tpg_pkg::*;
#(
   parameter int LSB_ZERO = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_sel,
   input  logic [31:0] wr_data,
   output tpg_ctrl_t   ctrl,
   output tpg_param_t  param,
   output tpg_slots_t  slots
);
   localparam int DATA_HI = TPG_CW - 1;
   localparam int MASK_LO = TPG_CW;
   localparam int MASK_HI = TPG_CW + TPG_NSLOT - 1;
   localparam int CTRL_W  = $bits(tpg_ctrl_t);

   initial assert (LSB_ZERO >= 0 && LSB_ZERO < TPG_CW)
      else $error("LSB_ZERO out of range");

   logic                 ctrl_wr, param_wr, col_wr;
   logic [TPG_NSLOT-1:0] pend_mask;

   assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
   assign param_wr = wr_en && (wr_sel == SEL_PARAM);
   assign col_wr   = wr_en && (wr_sel == SEL_COLOUR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl      <= '0;
         param     <= '0;
         pend_mask <= '0;
      end else begin
         if (ctrl_wr)  ctrl      <= tpg_ctrl_t'(wr_data[CTRL_W-1:0]);
         if (param_wr) param     <= tpg_param_t'(wr_data);
         if (col_wr)   pend_mask <= wr_data[MASK_HI:MASK_LO];
      end
   end

   // one store per colour component; data lands where the previous mask pointed
   for (genvar g = 0; g < TPG_NSLOT; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slots[g] <= '0;
         else if (col_wr && pend_mask[g])
            if (LSB_ZERO > 0)
               slots[g] <= {wr_data[DATA_HI:LSB_ZERO], {LSB_ZERO{1'b0}}};
            else
               slots[g] <= wr_data[DATA_HI:0];
      end
   end

   AST_SLOTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !col_wr |=> $stable(slots)) else $error("slots changed without colour write"); // R3
   AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      col_wr && (pend_mask == '0) |=> $stable(slots)) else $error("write with empty pending mask stored data"); // R3
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable(ctrl)) else $error("control changed without write"); // R11
   AST_PARAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !param_wr |=> $stable(param)) else $error("parameters changed without write"); // R12
endmodule

// File: rtl/tpg_pattern.sv
module tpg_pattern
   import tpg_pkg::*;
#(
   parameter int COORD_W = 14
) (
   input  tpg_ctrl_t           ctrl,
   input  tpg_param_t          param,
   input  tpg_slots_t          slots,
   input  logic [COORD_W-1:0]  pos_x,
   input  logic [COORD_W-1:0]  pos_y,
   output tpg_rgb_t            pat,
   output logic                pat_valid
);
   localparam int SW = COORD_W + TPG_CW + 1;          // ramp sum width
   localparam logic [TPG_CW-1:0] FULL    = '1;
   localparam logic [TPG_CW-1:0] CEA_HI  = TPG_CW'(235) << (TPG_CW - 8);
   localparam logic [TPG_CW-1:0] CEA_LO  = TPG_CW'(16)  << (TPG_CW - 8);

   initial assert (COORD_W >= 4 && COORD_W <= 16)
      else $error("COORD_W out of range");

   logic [COORD_W-1:0] bx;
   logic [2:0]         by_lo;
   logic [2:0]         sq_idx;
   logic [TPG_CW-1:0]  lvl_hi, lvl_lo;
   logic               alt_band;
   logic [3:0]         ramp_inc;
   logic [TPG_CW-1:0]  ramp_base;
   logic [SW-1:0]      ramp_sum;
   logic [TPG_CW-1:0]  ramp_val;
   logic [TPG_CW-1:0]  depth_mask;

   assign bx     = pos_x >> param.hres;
   assign by_lo  = 3'(pos_y >> param.vres);
   assign sq_idx = bx[2:0] + by_lo;
   assign lvl_hi = ctrl.cea ? CEA_HI : FULL;
   assign lvl_lo = ctrl.cea ? CEA_LO : '0;

   // second slope only on odd line bands of the dual ramp
   assign alt_band  = (ctrl.mode == MODE_RAMP2) && by_lo[0];
   assign ramp_inc  = alt_band ? param.inc1 : param.inc0;
   assign ramp_base = alt_band ? '0 : param.ofs;
   assign ramp_sum  = (SW'(bx) << ramp_inc) + SW'(ramp_base);
   assign ramp_val  = (|ramp_sum[SW-1:TPG_CW]) ? FULL : ramp_sum[TPG_CW-1:0];

   always_comb begin
      unique case (ctrl.depth)
         DEPTH_6:  depth_mask = FULL << (TPG_CW - 6);
         DEPTH_8:  depth_mask = FULL << (TPG_CW - 8);
         DEPTH_10: depth_mask = FULL << (TPG_CW - 10);
         default:  depth_mask = FULL << (TPG_CW - 12);
      endcase
   end

   always_comb begin
      pat_valid = ctrl.en;
      unique case (ctrl.mode)
         MODE_SQUARES, MODE_VBARS, MODE_HBARS, MODE_RAMP1, MODE_RAMP2: ;
         default: pat_valid = 1'b0;
      endcase
   end

   // component 0 = red, 1 = green, 2 = blue
   for (genvar c = 0; c < 3; c++) begin : g_comp
      logic [TPG_CW-1:0] raw;
      always_comb begin
         unique case (ctrl.mode)
            MODE_SQUARES: raw = sq_idx[2-c] ? lvl_hi : lvl_lo;
            MODE_VBARS:   raw = bx[0]    ? slots[c+3] : slots[c];
            MODE_HBARS:   raw = by_lo[0] ? slots[c+3] : slots[c];
            default:      raw = ramp_val;
         endcase
      end
      assign pat[c] = raw & depth_mask;
   end
endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen
   import tpg_pkg::*;
#(
   parameter int COORD_W  = 14,
   parameter int LSB_ZERO = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_sel,
   input  logic [31:0]        cfg_wdata,
   input  logic [COORD_W-1:0] pix_x,
   input  logic [COORD_W-1:0] pix_y,
   input  logic               pix_active,
   input  logic [47:0]        video_in,
   output logic [47:0]        pix_out
);
   localparam int PIX_W = 3 * TPG_CW;

   initial assert (PIX_W == 48) else $error("pixel width mismatch");

   tpg_ctrl_t  ctrl;
   tpg_param_t param;
   tpg_slots_t slots;
   tpg_rgb_t   pat;
   logic       pat_valid, pat_hit;

   tpg_regs #(.LSB_ZERO(LSB_ZERO)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel),
      .wr_data(cfg_wdata), .ctrl(ctrl), .param(param), .slots(slots)
   );

   tpg_pattern #(.COORD_W(COORD_W)) u_pat (
      .ctrl(ctrl), .param(param), .slots(slots), .pos_x(pix_x), .pos_y(pix_y),
      .pat(pat), .pat_valid(pat_valid)
   );

   assign pat_hit = pat_valid && pix_active;

   always_ff @(posedge clk) begin
      if (!rst_n)       pix_out <= '0;
      else if (pat_hit) pix_out <= {pat[0], pat[1], pat[2]};
      else              pix_out <= video_in;
   end

   AST_PASS_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_active |=> pix_out == $past(video_in)) else $error("inactive pixel altered"); // R2
   AST_PASS_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.en |=> pix_out == $past(video_in)) else $error("disabled generator altered pixel"); // R11
   AST_DEPTH6_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      pat_hit && ctrl.depth == DEPTH_6 |=>
         (pix_out[47:32] & 16'h03FF) == 0 && (pix_out[31:16] & 16'h03FF) == 0 &&
         (pix_out[15:0] & 16'h03FF) == 0) else $error("6-bit output has low bits"); // R10
   AST_DEPTH8_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      pat_hit && ctrl.depth == DEPTH_8 |=>
         pix_out[39:32] == 0 && pix_out[23:16] == 0 && pix_out[7:0] == 0)
      else $error("8-bit output has low bits"); // R10
endmodule

// File: tb/test_pattern_gen_tb.sv
module test_pattern_gen_tb;
   localparam int CW = 14;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          cfg_we = 0;
   logic [1:0]    cfg_sel = 0;
   logic [31:0]   cfg_wdata = 0;
   logic [CW-1:0] pix_x = 0, pix_y = 0;
   logic          pix_active = 0;
   logic [47:0]   video_in = 0;
   logic [47:0]   pix_out;

   int checks = 0, errors = 0;
   bit done = 0;

   // behavioural model state
   int m_en, m_mode, m_cea, m_depth;
   int m_inc0, m_inc1, m_hres, m_vres, m_ofs;
   int m_slot[6];
   int m_pend;

   always #10 clk = ~clk;   // 50 MHz

   test_pattern_gen #(.COORD_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .pix_x(pix_x), .pix_y(pix_y),
      .pix_active(pix_active), .video_in(video_in), .pix_out(pix_out)
   );

   task automatic check(input string tag, input logic [47:0] got, input logic [47:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [47:0] model(int x, int y, bit act, logic [47:0] vid);
      int bx, by, keep, v, idx, base, inc;
      logic [47:0] r;
      if (!act || m_en == 0 || m_mode > 4) return vid;
      bx = x >> m_hres;
      by = y >> m_vres;
      keep = 6 + 2 * m_depth;
      r = 0;
      for (int c = 0; c < 3; c++) begin
         case (m_mode)
            0: begin
               idx = (bx + by) % 8;
               if ((idx >> (2 - c)) % 2 == 1) v = m_cea ? 32'hEB00 : 32'hFFFF;
               else v = m_cea ? 32'h1000 : 0;
            end
            1: v = (bx % 2 == 1) ? m_slot[c+3] : m_slot[c];
            2: v = (by % 2 == 1) ? m_slot[c+3] : m_slot[c];
            default: begin
               if (m_mode == 4 && by % 2 == 1) begin base = 0; inc = m_inc1; end
               else begin base = m_ofs; inc = m_inc0; end
               v = base + (bx << inc);
               if (v > 65535) v = 65535;
            end
         endcase
         v = v & ((32'hFFFF << (16 - keep)) & 32'hFFFF);
         r[47 - 16*c -: 16] = v[15:0];
      end
      return r;
   endfunction

   task automatic model_write(input bit we, input int sel, input logic [31:0] d);
      if (!we) return;
      case (sel)
         0: begin m_en = d[0]; m_mode = d[3:1]; m_cea = d[4]; m_depth = d[6:5]; end
         1: begin m_inc0 = d[3:0]; m_inc1 = d[7:4]; m_hres = d[11:8];
                  m_vres = d[15:12]; m_ofs = d[31:16]; end
         2: begin
            for (int i = 0; i < 6; i++)
               if ((m_pend >> i) % 2 == 1) m_slot[i] = d[15:0] & 16'hFFC0;
            m_pend = d[21:16];
         end
         default: ;
      endcase
   endtask

   // one pixel clock: drive at falling edge, predict, clock, check at next falling edge
   task automatic cyc(input string tag, input bit we, input int sel, input logic [31:0] d,
                      input int x, input int y, input bit act, input logic [47:0] vid);
      logic [47:0] e;
      cfg_we = we; cfg_sel = sel[1:0]; cfg_wdata = d;
      pix_x = CW'(x); pix_y = CW'(y); pix_active = act; video_in = vid;
      e = model(x, y, act, vid);
      @(posedge clk);
      model_write(we, sel, d);
      @(negedge clk);
      check(tag, pix_out, e);
   endtask

   task automatic wr(input string tag, input int sel, input logic [31:0] d);
      cyc(tag, 1, sel, d, 0, 0, 1, 48'h0123_4567_89AB);
   endtask

   task automatic px(input string tag, input int x, input int y);
      cyc(tag, 0, 0, 0, x, y, 1, {16'(x), 16'(y), 16'h5A5A});
   endtask

   function automatic logic [31:0] ctl(int en, int mode, int cea, int depth);
      return 32'(en) | 32'(mode << 1) | 32'(cea << 4) | 32'(depth << 5);
   endfunction

   function automatic logic [31:0] prm(int i0, int i1, int h, int v, int o);
      return 32'(i0) | 32'(i1 << 4) | 32'(h << 8) | 32'(v << 12) | (32'(o) << 16);
   endfunction

   function automatic logic [31:0] col(int mask, int data);
      return (32'(mask) << 16) | 32'(data & 16'hFFFF);
   endfunction

   initial begin
      m_en = 0; m_mode = 0; m_cea = 0; m_depth = 0;
      m_inc0 = 0; m_inc1 = 0; m_hres = 0; m_vres = 0; m_ofs = 0; m_pend = 0;
      for (int i = 0; i < 6; i++) m_slot[i] = 0;

      // R1: reset holds the output at zero
      pix_active = 1; video_in = 48'hFFFF_FFFF_FFFF;
      repeat (3) @(negedge clk);
      check("R1 reset output", pix_out, 48'h0);
      rst_n = 1;

      // R2: generator off after reset, video passes
      for (int i = 0; i < 4; i++) px("R2 pass after reset", i * 3, i);

      // R3/R4: seven-write colour load; first data goes nowhere
      wr("R3 load first", 2, col(6'h01, 16'hABCD));
      wr("R3 load R0", 2, col(6'h02, 16'h12FF));  // R4 low bits dropped
      wr("R3 load G0", 2, col(6'h04, 16'h3400));
      wr("R3 load B0", 2, col(6'h08, 16'h5641));
      wr("R3 load R1", 2, col(6'h10, 16'hF00F));
      wr("R3 load G1", 2, col(6'h20, 16'h0FC0));
      wr("R3 load B1", 2, col(6'h20, 16'hC33F));

      // R5: vertical bars, 12-bit depth, 4-pixel bars
      wr("R12 params", 1, prm(0, 0, 2, 1, 0));
      wr("R11 ctrl vbars", 0, ctl(1, 1, 0, 3));
      for (int x = 0; x < 16; x++) px("R5 vbars", x, 0);

      // R3: a write with empty pending mask changes nothing; then a steered write
      wr("R3 mask clear", 2, col(6'h00, 16'h0000));
      wr("R3 empty mask", 2, col(6'h00, 16'h7777));
      for (int x = 0; x < 8; x++) px("R3 bars unchanged", x, 5);
      wr("R3 pend R1", 2, col(6'h08, 16'h0000));
      wr("R3 write R1", 2, col(6'h00, 16'h8880));
      for (int x = 0; x < 8; x++) px("R3 R1 updated", x, 2);

      // R6: horizontal bars, 8-bit depth
      wr("R11 ctrl hbars", 0, ctl(1, 2, 0, 1));
      for (int y = 0; y < 8; y++) px("R6 hbars", 7, y);

      // R7: colour squares, VESA then limited range, 10-bit
      wr("R12 params sq", 1, prm(0, 0, 6, 6, 0));
      wr("R11 ctrl sq", 0, ctl(1, 0, 0, 2));
      for (int k = 0; k < 10; k++) px("R7 squares full", k * 64, (k % 3) * 64);
      wr("R11 ctrl sq cea", 0, ctl(1, 0, 1, 2));
      for (int k = 0; k < 10; k++) px("R7 squares limited", k * 64 + 5, k * 64);

      // R8: single ramp, 6-bit and 8-bit, then saturation
      wr("R12 params r6", 1, prm(10, 0, 6, 6, 0));
      wr("R11 ctrl r6", 0, ctl(1, 3, 0, 0));
      for (int k = 0; k < 8; k++) px("R8 ramp 6bit", k * 64 + 3, 0);
      wr("R12 params r8", 1, prm(8, 0, 8, 6, 0));
      wr("R11 ctrl r8", 0, ctl(1, 3, 0, 1));
      for (int k = 0; k < 8; k++) px("R8 ramp 8bit", k * 256 + 17, 9);
      wr("R12 params sat", 1, prm(8, 0, 8, 6, 16'hF000));
      for (int k = 0; k < 40; k += 4) px("R8 ramp saturate", k * 256, 0);

      // R9: dual ramp, 10-bit
      wr("R12 params dual", 1, prm(6, 8, 8, 5, 384 << 6));
      wr("R11 ctrl dual", 0, ctl(1, 4, 0, 2));
      for (int k = 0; k < 12; k++) px("R9 dual even band", k * 256, 3);
      for (int k = 0; k < 12; k++) px("R9 dual odd band", k * 256, 40);

      // R10: fine ramp exposes truncation at every depth
      wr("R12 params fine", 1, prm(0, 0, 0, 0, 16'h0FFF));
      for (int dp = 0; dp < 4; dp++) begin
         wr("R10 depth ctrl", 0, ctl(1, 3, 0, dp));
         for (int x = 0; x < 6; x++) px("R10 depth trunc", x * 37, 0);
      end

      // R2: inactive pixels and reserved modes pass through
      for (int x = 0; x < 4; x++) cyc("R2 inactive", 0, 0, 0, x, 0, 0, 48'hDEAD_BEEF_0001);
      wr("R2 reserved mode", 0, ctl(1, 6, 0, 3));
      for (int x = 0; x < 4; x++) px("R2 reserved mode pass", x, x);

      // R11: zeros to all targets restore pass-through
      wr("R11 ctrl on", 0, ctl(1, 1, 0, 3));
      wr("R11 zero ctrl", 0, 0);
      wr("R11 zero colour", 2, 0);
      wr("R11 zero params", 1, 0);
      for (int x = 0; x < 6; x++) px("R11 pass after zero", x * 11, x);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      done = 1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule